// File: doc/BRIEF.md
# D-PHY Timing Count Generator

This block turns a per-lane link rate, given in MHz, into the set of high-speed, turnaround and clock-lane timing counts that a D-PHY transmitter needs. All counts are expressed in byte-clock cycles. Each count comes from a fixed linear expression in the rate. The expression is divided by 8000 with the result rounded down, and one is then added. A few counts are derived from others: the turnaround counts are multiples of the low-power period, and two zero-phase counts subtract a prepare count.

A single-cycle start pulse, taken only while the unit is idle, captures the rate. One shared restoring divider is then time-multiplexed over eight quotients. When the results are ready, four 32-bit configuration words are updated and a one-cycle done pulse marks them valid. Each word holds four 8-bit fields. An overflow flag reports when any count did not fit its 8-bit field.

Top module: `dphy_timing_calc`

## Requirements
- R1: While reset is held and after it is released, done_o, busy_o and ovf_o are 0 and all four words are zero.
- R2: A start pulse seen while idle captures rate_i, and busy_o reads 1 from the next cycle until the result is published.
- R3: done_o is a one-cycle pulse. It rises in the same cycle that busy_o falls, and it arrives within 8*(RATE_W+12)+4 cycles of the start.
- R4: A start pulse while busy_o is 1 is ignored: the pending result still reflects the first rate, and only one done pulse follows.
- R5: word0_o holds, from bit 0 upward in bytes, the low-power period L=floor(80R/8000)+1, the data prepare P=floor((59R+4000)/8000)+1, the data zero floor((163R+11000)/8000)+1-P, and the trail T=floor((78R+7000)/8000)+1.
- R6: word1_o holds, from bit 0 upward, 4L, floor(3L/2), 5L and the exit count floor(118R/8000)+1.
- R7: word2_o holds 0 in bits [7:0], 1 in bits [15:8], the clock zero count floor(330R/8000)+1-C in bits [23:16] (C = clock prepare), and T in bits [31:24].
- R8: word3_o holds C=floor(57R/8000)+1 in bits [7:0], the clock post count floor((65R+53000)/8000)+1 in bits [15:8], the exit count in bits [23:16], and 0 in bits [31:24].
- R9: Each field carries the low 8 bits of its count. ovf_o is 1 exactly when some count exceeds 255.
- R10: The words and ovf_o change only in the cycle where done_o is 1 and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle launch request |
| rate_i | input | RATE_W | Per-lane link rate in MHz |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| ovf_o | output | 1 | Some count exceeded 8 bits |
| word0_o | output | 32 | Data-lane HS timing word |
| word1_o | output | 32 | Turnaround and exit word |
| word2_o | output | 32 | Sync, clock-zero and trail word |
| word3_o | output | 32 | Clock prepare, post and exit word |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a calculation. The stimulus launches one rate, then drives a second start with a different rate several divider passes later. It then confirms that the published words belong to the first rate and that no second done pulse appears. The overflow boundary sits where the largest turnaround count first passes 255, at a rate of 5100 MHz. A dense sweep of low rates is therefore combined with a strided sweep up to the top of the rate range and with explicit points on both sides of that boundary.

// File: rtl/dphy_tcalc_pkg.sv
package dphy_tcalc_pkg;

   localparam int unsigned TC_NSTEP   = 8;
   localparam int unsigned TC_DIVISOR = 8000;

   // quotient slots, in launch order
   localparam int unsigned Q_LPX   = 0;
   localparam int unsigned Q_DPREP = 1;
   localparam int unsigned Q_DZRAW = 2;
   localparam int unsigned Q_TRAIL = 3;
   localparam int unsigned Q_EXIT  = 4;
   localparam int unsigned Q_CPREP = 5;
   localparam int unsigned Q_CPOST = 6;
   localparam int unsigned Q_CZRAW = 7;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LAUNCH,
      ST_WAIT,
      ST_FIN
   } tc_state_e;

   function automatic logic [15:0] tc_coef(input int unsigned idx);
      case (idx)
         Q_LPX:   return 16'd80;
         Q_DPREP: return 16'd59;
         Q_DZRAW: return 16'd163;
         Q_TRAIL: return 16'd78;
         Q_EXIT:  return 16'd118;
         Q_CPREP: return 16'd57;
         Q_CPOST: return 16'd65;
         default: return 16'd330;
      endcase
   endfunction

   function automatic logic [15:0] tc_offs(input int unsigned idx);
      case (idx)
         Q_DPREP: return 16'd4000;
         Q_DZRAW: return 16'd11000;
         Q_TRAIL: return 16'd7000;
         Q_CPOST: return 16'd53000;
         default: return 16'd0;
      endcase
   endfunction

endpackage

// File: rtl/dphy_tcalc_div.sv
module dphy_tcalc_div #(
   parameter int unsigned NUM_W   = 24,
   parameter int unsigned DIVISOR = 8000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NUM_W-1:0] num_i,
   output logic             done_o,
   output logic [NUM_W-1:0] quo_o
);
   localparam int unsigned DEN_W = $clog2(DIVISOR + 1);
   localparam int unsigned CNT_W = $clog2(NUM_W + 1);
   localparam logic [DEN_W:0] DIV_V = (DEN_W+1)'(DIVISOR);

   generate
      if (DIVISOR < 2) begin : g_bad_div
         $error("dphy_tcalc_div: DIVISOR must be at least 2");
      end
      if (NUM_W < 2) begin : g_bad_num
         $error("dphy_tcalc_div: NUM_W must be at least 2");
      end
   endgenerate

   logic [DEN_W-1:0] rem_q;
   logic [NUM_W-1:0] q_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic [DEN_W:0]   trial;

   assign trial  = {rem_q, q_q[NUM_W-1]};
   assign done_o = done_q;
   assign quo_o  = q_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         q_q    <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            rem_q <= '0;
            q_q   <= num_i;
            cnt_q <= CNT_W'(NUM_W);
         end else if (cnt_q != '0) begin
            if (trial >= DIV_V) begin
               rem_q <= DEN_W'(trial - DIV_V);
               q_q   <= {q_q[NUM_W-2:0], 1'b1};
            end else begin
               rem_q <= trial[DEN_W-1:0];
               q_q   <= {q_q[NUM_W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
         end
      end
   end

   // R5
   rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rem_q < DIV_V[DEN_W-1:0]);

   // R3
   div_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/dphy_tcalc_ctrl.sv
module dphy_tcalc_ctrl
   import dphy_tcalc_pkg::*;
#(
   parameter int unsigned RATE_W = 14,
   parameter int unsigned NUM_W  = 24,
   parameter int unsigned RES_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              div_done_i,
   input  logic [NUM_W-1:0]  div_quo_i,
   output logic              div_start_o,
   output logic [NUM_W-1:0]  div_num_o,
   output logic              busy_o,
   output logic              fin_o,
   output logic [RES_W-1:0]  res_o [TC_NSTEP]
);
   localparam int unsigned SW = $clog2(TC_NSTEP);

   tc_state_e         state_q;
   logic [RATE_W-1:0] rate_q;
   logic [SW-1:0]     step_q;
   logic [RES_W-1:0]  res_q [TC_NSTEP];

   assign div_start_o = (state_q == ST_LAUNCH);
   assign fin_o       = (state_q == ST_FIN);
   assign busy_o      = (state_q != ST_IDLE);
   assign div_num_o   = NUM_W'(tc_coef(32'(step_q))) * NUM_W'(rate_q)
                      + NUM_W'(tc_offs(32'(step_q)));

   generate
      for (genvar i = 0; i < TC_NSTEP; i++) begin : g_res
         assign res_o[i] = res_q[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rate_q  <= '0;
         step_q  <= '0;
         for (int i = 0; i < TC_NSTEP; i++) res_q[i] <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  rate_q  <= rate_i;
                  step_q  <= '0;
                  state_q <= ST_LAUNCH;
               end
            end
            ST_LAUNCH: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (div_done_i) begin
                  res_q[step_q] <= RES_W'(div_quo_i) + RES_W'(1);
                  if (step_q == SW'(TC_NSTEP - 1)) begin
                     state_q <= ST_FIN;
                  end else begin
                     step_q  <= step_q + 1'b1;
                     state_q <= ST_LAUNCH;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R4
   rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(rate_q));

   // R2
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && div_start_o));

endmodule

// File: rtl/dphy_tcalc_pack.sv
module dphy_tcalc_pack
   import dphy_tcalc_pkg::*;
#(
   parameter int unsigned RES_W = 16,
   parameter int unsigned FLD_W = 8,
   parameter int unsigned NWORD = 4
) (
   input  logic [RES_W-1:0]       res_i [TC_NSTEP],
   output logic [FLD_W*4-1:0]     word_o [NWORD],
   output logic                   ovf_o
);
   localparam int unsigned NFLD = NWORD * 4;

   generate
      if (RES_W <= FLD_W + 2) begin : g_bad_res
         $error("dphy_tcalc_pack: RES_W must exceed FLD_W by more than 2");
      end
      if (NWORD != 4) begin : g_bad_nword
         $error("dphy_tcalc_pack: the layout defines exactly four words");
      end
   endgenerate

   logic [RES_W-1:0] lpx, dzero, czero, ta_go, ta_sure, ta_get;
   logic [RES_W-1:0] fld [NFLD];
   logic [NFLD-1:0]  big;

   always_comb begin
      lpx     = res_i[Q_LPX];
      dzero   = res_i[Q_DZRAW] - res_i[Q_DPREP];
      czero   = res_i[Q_CZRAW] - res_i[Q_CPREP];
      ta_go   = lpx << 2;
      ta_sure = (lpx + (lpx << 1)) >> 1;
      ta_get  = lpx + (lpx << 2);
   end

   // field table, low byte first within each word
   assign fld[0]  = lpx;
   assign fld[1]  = res_i[Q_DPREP];
   assign fld[2]  = dzero;
   assign fld[3]  = res_i[Q_TRAIL];
   assign fld[4]  = ta_go;
   assign fld[5]  = ta_sure;
   assign fld[6]  = ta_get;
   assign fld[7]  = res_i[Q_EXIT];
   assign fld[8]  = '0;
   assign fld[9]  = RES_W'(1);
   assign fld[10] = czero;
   assign fld[11] = res_i[Q_TRAIL];
   assign fld[12] = res_i[Q_CPREP];
   assign fld[13] = res_i[Q_CPOST];
   assign fld[14] = res_i[Q_EXIT];
   assign fld[15] = '0;

   generate
      for (genvar w = 0; w < NWORD; w++) begin : g_word
         for (genvar b = 0; b < 4; b++) begin : g_byte
            assign word_o[w][FLD_W*b +: FLD_W] = fld[4*w+b][FLD_W-1:0];
         end
      end
      for (genvar f = 0; f < NFLD; f++) begin : g_big
         assign big[f] = |fld[f][RES_W-1:FLD_W];
      end
   endgenerate

   assign ovf_o = |big;

endmodule

// File: rtl/dphy_timing_calc.sv
module dphy_timing_calc
   import dphy_tcalc_pkg::*;
#(
   parameter int unsigned RATE_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              ovf_o,
   output logic [31:0]       word0_o,
   output logic [31:0]       word1_o,
   output logic [31:0]       word2_o,
   output logic [31:0]       word3_o
);
   localparam int unsigned NUM_W = RATE_W + 10;
   localparam int unsigned RES_W = 16;
   localparam int unsigned NWORD = 4;

   generate
      if (RATE_W < 4 || RATE_W > 20) begin : g_bad_rate
         $error("dphy_timing_calc: RATE_W must lie in 4..20");
      end
   endgenerate

   logic             d_start, d_done, fin, c_busy, p_ovf;
   logic [NUM_W-1:0] d_num, d_quo;
   logic [RES_W-1:0] res [TC_NSTEP];
   logic [31:0]      p_word [NWORD];
   logic [31:0]      word_q [NWORD];
   logic             ovf_q, done_q;

   dphy_tcalc_ctrl #(.RATE_W(RATE_W), .NUM_W(NUM_W), .RES_W(RES_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i),
      .div_done_i(d_done), .div_quo_i(d_quo), .div_start_o(d_start),
      .div_num_o(d_num), .busy_o(c_busy), .fin_o(fin), .res_o(res)
   );

   dphy_tcalc_div #(.NUM_W(NUM_W), .DIVISOR(TC_DIVISOR)) u_div (
      .clk(clk), .rst_n(rst_n), .start_i(d_start), .num_i(d_num),
      .done_o(d_done), .quo_o(d_quo)
   );

   dphy_tcalc_pack #(.RES_W(RES_W), .FLD_W(8), .NWORD(NWORD)) u_pack (
      .res_i(res), .word_o(p_word), .ovf_o(p_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NWORD; i++) word_q[i] <= '0;
         ovf_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= fin;
         if (fin) begin
            for (int i = 0; i < NWORD; i++) word_q[i] <= p_word[i];
            ovf_q <= p_ovf;
         end
      end
   end

   assign busy_o  = c_busy;
   assign done_o  = done_q;
   assign ovf_o   = ovf_q;
   assign word0_o = word_q[0];
   assign word1_o = word_q[1];
   assign word2_o = word_q[2];
   assign word3_o = word_q[3];

   // R3
   done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R7
   word2_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (word2_o[15:0] == 16'h0100));

   // R8
   word3_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (word3_o[31:24] == 8'h00));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(word0_o) && $stable(word1_o) && $stable(word2_o)
                   && $stable(word3_o) && $stable(ovf_o)));

endmodule

// File: tb/dphy_timing_calc_test.sv
module dphy_timing_calc_test;
   localparam int RATE_W = 14;
   localparam int LIMIT  = 8 * (RATE_W + 12) + 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [RATE_W-1:0] rate_i = '0;
   logic busy_o, done_o, ovf_o;
   logic [31:0] word0_o, word1_o, word2_o, word3_o;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 0;

   always #10 clk = ~clk;

   dphy_timing_calc #(.RATE_W(RATE_W)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i),
      .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o),
      .word0_o(word0_o), .word1_o(word1_o), .word2_o(word2_o), .word3_o(word3_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model(input int r, output logic [31:0] w0, output logic [31:0] w1,
                        output logic [31:0] w2, output logic [31:0] w3, output logic ov);
      int lpx, hp, hz, tr, tg, ts, tt, ex, cp, cpo, cz;
      lpx = 80 * r / 8000 + 1;
      hp  = (59 * r + 4000) / 8000 + 1;
      hz  = (163 * r + 11000) / 8000 + 1 - hp;
      tr  = (78 * r + 7000) / 8000 + 1;
      tg  = 4 * lpx;
      ts  = 3 * lpx / 2;
      tt  = 5 * lpx;
      ex  = 118 * r / 8000 + 1;
      cp  = 57 * r / 8000 + 1;
      cpo = (65 * r + 53000) / 8000 + 1;
      cz  = 330 * r / 8000 + 1 - cp;
      w0 = {tr[7:0], hz[7:0], hp[7:0], lpx[7:0]};
      w1 = {ex[7:0], tt[7:0], ts[7:0], tg[7:0]};
      w2 = {tr[7:0], cz[7:0], 8'd1, 8'd0};
      w3 = {8'd0, ex[7:0], cpo[7:0], cp[7:0]};
      ov = (lpx > 255) || (hp > 255) || (hz > 255) || (tr > 255) || (tg > 255) ||
           (ts > 255) || (tt > 255) || (ex > 255) || (cp > 255) || (cpo > 255) ||
           (cz > 255);
   endtask

   task automatic pulse_start(input int r);
      @(negedge clk);
      start_i = 1'b1;
      rate_i  = RATE_W'(r);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic await_done(output bit seen);
      seen = 0;
      for (int i = 0; i < LIMIT; i++) begin
         if (done_o) begin
            seen = 1;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic compare(input int r);
      logic [31:0] e0, e1, e2, e3;
      logic eo;
      model(r, e0, e1, e2, e3, eo);
      check("R5 word0", word0_o, e0);
      check("R6 word1", word1_o, e1);
      check("R7 word2", word2_o, e2);
      check("R8 word3", word3_o, e3);
      check("R9 ovf", {31'd0, ovf_o}, {31'd0, eo});
   endtask

   task automatic run(input int r);
      bit seen;
      pulse_start(r);
      check("R2 busy after start", {31'd0, busy_o}, 32'd1);
      await_done(seen);
      check("R3 done within bound", {31'd0, seen}, 32'd1);
      if (seen) begin
         check("R3 busy low at done", {31'd0, busy_o}, 32'd0);
         compare(r);
         @(negedge clk);
         check("R3 done single cycle", {31'd0, done_o}, 32'd0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      bit seen;
      logic [31:0] h0, h1, h2, h3;
      logic ho;
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1 done", {31'd0, done_o}, 32'd0);
      check("R1 busy", {31'd0, busy_o}, 32'd0);
      check("R1 ovf", {31'd0, ovf_o}, 32'd0);
      check("R1 words", word0_o | word1_o | word2_o | word3_o, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle after release", {29'd0, busy_o, done_o, ovf_o}, 32'd0);
      check("R1 words after release", word0_o | word1_o | word2_o | word3_o, 32'd0);

      // dense low sweep
      for (int r = 0; r < 300; r++) run(r);
      // strided sweep to the top of the range
      for (int r = 300; r < 16384; r += 131) run(r);
      // R9 overflow boundary and extremes
      run(5099);
      run(5100);
      run(7999);
      run(8000);
      run(16383);

      // R4: restart while busy is ignored
      pulse_start(1000);
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      rate_i  = RATE_W'(50);
      @(negedge clk);
      start_i = 1'b0;
      await_done(seen);
      check("R4 first done", {31'd0, seen}, 32'd1);
      compare(1000);
      @(negedge clk);
      seen = 0;
      for (int i = 0; i < LIMIT + 20; i++) begin
         if (done_o || busy_o) seen = 1;
         @(negedge clk);
      end
      check("R4 no second calculation", {31'd0, seen}, 32'd0);

      // R10: outputs hold between results
      h0 = word0_o; h1 = word1_o; h2 = word2_o; h3 = word3_o; ho = ovf_o;
      rate_i = RATE_W'(9999);
      repeat (30) @(negedge clk);
      check("R10 word0 hold", word0_o, h0);
      check("R10 word1 hold", word1_o, h1);
      check("R10 word2 hold", word2_o, h2);
      check("R10 word3 hold", word3_o, h3);
      check("R10 ovf hold", {31'd0, ovf_o}, {31'd0, ho});

      if (!ended) begin
         ended = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule